// File: doc/BRIEF.md
# Interleaved Burst Framing Checker

This block sits next to an eight-word transmit user bus that carries packets from up to sixteen channels. Each packet may be cut into bursts, and bursts from different channels may interleave on the bus. The checker watches the start-of-packet, start-of-burst and end-of-burst strobes, the channel number, the valid-word count and the 4-bit end-of-packet code. It flags every beat that breaks burst or packet framing. It does not touch the bus and does not look at the payload.

Two kinds of state are kept, one for bursts and one for packets. Burst state is global, because only one burst can be in flight on the bus: the checker records whether a burst is open and which channel opened it. Packet state is kept per channel as one open/closed bit, so each channel's packet can span several bursts that interleave with bursts of other channels. A beat is any cycle whose valid-word count is nonzero. The channel input is sampled only when start-of-burst is high. Every other beat belongs to the channel that opened the current burst.

On each violating beat, `viol_o` pulses for one cycle, one clock after that beat. In the same cycle, the matching bits of the sticky `err_o` vector are set, and they stay set until reset.

Top module: `burst_frame_chk`

## Requirements
- R1: During reset and right after it, `err_o` is all zero and `viol_o` is low; no burst is open and every channel's packet is closed.
- R2: A cycle with valid-word count zero is idle. It raises no error and changes no burst or packet state, whatever the other inputs carry.
- R3: Start-of-burst on a beat while a burst is already open sets `err_o[0]`.
- R4: A beat without start-of-burst while no burst is open sets `err_o[1]`.
- R5: Start-of-packet on a beat whose channel already has an open packet sets `err_o[2]`.
- R6: Start-of-burst without start-of-packet, for a channel with no open packet, sets `err_o[3]`.
- R7: Start-of-packet on a beat without start-of-burst sets `err_o[4]`.
- R8: An end-of-packet code with bit 3 set, on a beat without end-of-burst, sets `err_o[5]`.
- R9: A valid-word count above 8 sets `err_o[6]`.
- R10: An end-of-packet code with bit 3 clear but bits 2:0 nonzero sets `err_o[7]`. The only legal non-final code is 4'b0000.
- R11: The channel input is used only on start-of-burst beats. On other beats the channel of the open burst applies, and the channel input is ignored.
- R12: End-of-burst closes the burst but leaves the packet open. Code bit 3 closes the channel's packet. A beat with start-of-packet, start-of-burst, end-of-burst and code bit 3 all set is a complete packet.
- R13: Packet state is independent per channel, so bursts of different channels may interleave freely.
- R14: `viol_o` is high exactly in the cycle after a beat that raised at least one error. The bits of `err_o` only ever get set, and only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sop_i | input | 1 | Start of packet |
| sob_i | input | 1 | Start of burst |
| eob_i | input | 1 | End of burst |
| chan_i | input | 4 | Channel, sampled with start-of-burst |
| nvalid_i | input | 4 | Valid-word count, 0 means idle |
| eop_code_i | input | 4 | Bit 3 marks the last beat of the packet; bits 2:0 give the valid bytes in the last word |
| viol_o | output | 1 | One-cycle violation pulse |
| err_o | output | 8 | Sticky error flags, bit positions as in R3 to R10 |

## Verification
A wrong burst-open bit or a wrong burst channel shows up on the next beat. It appears as a spurious or missing `err_o[0]`, `err_o[1]`, or a per-channel packet error. A wrong per-channel packet bit may stay hidden until that channel next starts a burst, which can be many beats later when traffic is interleaved. For that reason the sequences close packets on one channel and then reopen or continue them after beats of other channels. Every error becomes visible on the ports exactly one cycle after the offending beat.

// File: rtl/burst_frame_pkg.sv
package burst_frame_pkg;
  localparam int unsigned ERR_N = 8;

  localparam int unsigned ERR_SOB_OPEN   = 0;
  localparam int unsigned ERR_NO_BURST   = 1;
  localparam int unsigned ERR_SOP_OPEN   = 2;
  localparam int unsigned ERR_NO_PKT     = 3;
  localparam int unsigned ERR_SOP_NO_SOB = 4;
  localparam int unsigned ERR_EOP_NO_EOB = 5;
  localparam int unsigned ERR_CNT_RANGE  = 6;
  localparam int unsigned ERR_EOP_CODE   = 7;

  typedef logic [ERR_N-1:0] err_vec_t;

  typedef struct packed {
    logic       flag;
    logic [2:0] bytes;
  } eop_code_t;
endpackage

// File: rtl/burst_frame_burst_trk.sv
module burst_frame_burst_trk #(
  parameter int unsigned CH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            beat_i,
  input  logic            sob_i,
  input  logic            eob_i,
  input  logic [CH_W-1:0] chan_i,
  output logic            open_o,
  output logic [CH_W-1:0] cur_ch_o
);
  logic            open_q;
  logic [CH_W-1:0] ch_q;

  // channel is only captured at burst start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      ch_q   <= '0;
    end else if (beat_i) begin
      open_q <= ~eob_i;
      if (sob_i) ch_q <= chan_i;
    end
  end

  assign open_o   = open_q;
  assign cur_ch_o = ch_q;
endmodule

// File: rtl/burst_frame_pkt_tbl.sv
module burst_frame_pkt_tbl #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic              set_i,
  input  logic              clr_i,
  output logic [NUM_CH-1:0] open_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic open_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0;
      end else if (upd_i && ch_i == CH_W'(c)) begin
        // end flag wins: a one-beat packet leaves the channel closed
        open_q <= clr_i ? 1'b0 : (set_i | open_q);
      end
    end
    assign open_o[c] = open_q;
  end
endmodule

// File: rtl/burst_frame_rules.sv
module burst_frame_rules
  import burst_frame_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned CNT_W     = 4
) (
  input  logic       sop_i,
  input  logic       sob_i,
  input  logic       eob_i,
  input  logic [CNT_W-1:0] nvalid_i,
  input  eop_code_t  eop_i,
  input  logic       burst_open_i,
  input  logic       pkt_open_i,
  output logic       beat_o,
  output err_vec_t   err_o
);
  logic beat;

  assign beat   = (nvalid_i != '0);
  assign beat_o = beat;

  always_comb begin
    err_o = '0;
    if (beat) begin
      err_o[ERR_SOB_OPEN]   = sob_i & burst_open_i;
      err_o[ERR_NO_BURST]   = ~sob_i & ~burst_open_i;
      err_o[ERR_SOP_OPEN]   = sop_i & pkt_open_i;
      err_o[ERR_NO_PKT]     = sob_i & ~sop_i & ~pkt_open_i;
      err_o[ERR_SOP_NO_SOB] = sop_i & ~sob_i;
      err_o[ERR_EOP_NO_EOB] = eop_i.flag & ~eob_i;
      err_o[ERR_CNT_RANGE]  = (nvalid_i > CNT_W'(NUM_WORDS));
      err_o[ERR_EOP_CODE]   = ~eop_i.flag & (eop_i.bytes != 3'd0);
    end
  end
endmodule

// File: rtl/burst_frame_err_reg.sv
module burst_frame_err_reg
  import burst_frame_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  err_vec_t err_i,
  output logic     viol_o,
  output err_vec_t sticky_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o   <= 1'b0;
      sticky_o <= '0;
    end else begin
      viol_o   <= |err_i;
      sticky_o <= sticky_o | err_i;
    end
  end
endmodule

// File: rtl/burst_frame_chk.sv
module burst_frame_chk
  import burst_frame_pkg::*;
#(
  parameter int unsigned NUM_CH    = 16,
  parameter int unsigned NUM_WORDS = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned CNT_W = $clog2(NUM_WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sop_i,
  input  logic             sob_i,
  input  logic             eob_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [CNT_W-1:0] nvalid_i,
  input  logic [3:0]       eop_code_i,
  output logic             viol_o,
  output logic [ERR_N-1:0] err_o
);
  logic              beat;
  logic              burst_open;
  logic [CH_W-1:0]   burst_ch;
  logic [CH_W-1:0]   eff_ch;
  logic [NUM_CH-1:0] pkt_open;
  eop_code_t         eop;
  err_vec_t          err_now;

  assign eop    = eop_code_t'(eop_code_i);
  assign eff_ch = sob_i ? chan_i : burst_ch;

  burst_frame_burst_trk #(.CH_W(CH_W)) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .beat_i   (beat),
    .sob_i    (sob_i),
    .eob_i    (eob_i),
    .chan_i   (chan_i),
    .open_o   (burst_open),
    .cur_ch_o (burst_ch)
  );

  burst_frame_pkt_tbl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pkt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (beat),
    .ch_i   (eff_ch),
    .set_i  (sop_i),
    .clr_i  (eop.flag),
    .open_o (pkt_open)
  );

  burst_frame_rules #(.NUM_WORDS(NUM_WORDS), .CNT_W(CNT_W)) u_rules (
    .sop_i        (sop_i),
    .sob_i        (sob_i),
    .eob_i        (eob_i),
    .nvalid_i     (nvalid_i),
    .eop_i        (eop),
    .burst_open_i (burst_open),
    .pkt_open_i   (pkt_open[eff_ch]),
    .beat_o       (beat),
    .err_o        (err_now)
  );

  burst_frame_err_reg u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .err_i    (err_now),
    .viol_o   (viol_o),
    .sticky_o (err_o)
  );
endmodule

// File: rtl/burst_frame_chk_sva.sv
module burst_frame_chk_sva
  import burst_frame_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8,
  localparam int unsigned CNT_W = $clog2(NUM_WORDS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sop_i,
  input logic             sob_i,
  input logic             eob_i,
  input logic [CNT_W-1:0] nvalid_i,
  input logic [3:0]       eop_code_i,
  input logic             viol_o,
  input logic [ERR_N-1:0] err_o
);
  logic beat;
  assign beat = (nvalid_i != '0);

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((err_o & $past(err_o)) == $past(err_o))); // R14
  AST_VIOL_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (err_o != '0)); // R14
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat |=> !viol_o); // R2
  AST_SOP_NEEDS_SOB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && sop_i && !sob_i) |=> (viol_o && err_o[ERR_SOP_NO_SOB])); // R7
  AST_EOP_NEEDS_EOB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && eop_code_i[3] && !eob_i) |=> (viol_o && err_o[ERR_EOP_NO_EOB])); // R8
  AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nvalid_i > CNT_W'(NUM_WORDS)) |=> (viol_o && err_o[ERR_CNT_RANGE])); // R9
  AST_EOP_CODE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && !eop_code_i[3] && eop_code_i[2:0] != 3'd0) |=> (viol_o && err_o[ERR_EOP_CODE])); // R10
endmodule

bind burst_frame_chk burst_frame_chk_sva #(.NUM_WORDS(NUM_WORDS)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sop_i      (sop_i),
  .sob_i      (sob_i),
  .eob_i      (eob_i),
  .nvalid_i   (nvalid_i),
  .eop_code_i (eop_code_i),
  .viol_o     (viol_o),
  .err_o      (err_o)
);

// File: tb/burst_frame_chk_bench.sv
`timescale 1ns/1ps
module burst_frame_chk_bench;
  localparam int ERR_N = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sop = 0, sob = 0, eob = 0;
  logic [3:0]       chan = '0;
  logic [3:0]       nvalid = '0;
  logic [3:0]       eop = '0;
  logic             viol;
  logic [ERR_N-1:0] err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [ERR_N-1:0] vec;
    string            tag;
  } exp_t;
  exp_t             exp_q[$];
  logic [ERR_N-1:0] sticky_m = '0;

  always #2 clk = ~clk;

  burst_frame_chk u_burst_frame_chk (
    .clk_i(clk), .rst_ni(rst_n), .sop_i(sop), .sob_i(sob), .eob_i(eob),
    .chan_i(chan), .nvalid_i(nvalid), .eop_code_i(eop),
    .viol_o(viol), .err_o(err)
  );

  // monitor: compares after each edge that consumed a driven beat
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        sticky_m = sticky_m | it.vec;
        total++;
        if (viol !== (it.vec != '0) || err !== sticky_m) begin
          bad++;
          $display("FAIL %s: viol=%0b err=%b expected viol=%0b err=%b",
                   it.tag, viol, err, (it.vec != '0), sticky_m);
        end
      end
    end
  end

  task automatic beat(input logic s_p, input logic s_b, input logic e_b,
                      input int ch, input int nv, input logic [3:0] code,
                      input logic [ERR_N-1:0] exp_vec, input string tag);
    exp_t it;
    @(negedge clk);
    sop = s_p; sob = s_b; eob = e_b;
    chan = 4'(ch); nvalid = 4'(nv); eop = code;
    it.vec = exp_vec;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic quiet();
    @(negedge clk);
    sop = 0; sob = 0; eob = 0; nvalid = '0; eop = '0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    quiet();
    rst_n = 1'b0;
    sticky_m = '0;
    repeat (2) @(negedge clk);
    total++;
    if (viol !== 1'b0 || err !== '0) begin
      bad++;
      $display("FAIL R1: viol=%0b err=%b expected viol=0 err=0", viol, err);
    end
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // clean interleaved traffic
    beat(1,1,0, 2,8,4'b0000, 8'h00, "R13 ch2 pkt start");
    beat(0,0,1, 9,8,4'b0000, 8'h00, "R12 ch2 burst end, chan ignored R11");
    beat(1,1,0, 5,0,4'b1000, 8'h00, "R2 idle with junk strobes");
    beat(1,1,1, 4,3,4'b1011, 8'h00, "R12 one-beat packet ch4");
    beat(0,1,1, 2,8,4'b0000, 8'h00, "R12 ch2 continuation burst");
    beat(1,1,0, 7,8,4'b0000, 8'h00, "R13 ch7 pkt start");
    beat(0,0,1, 0,2,4'b1011, 8'h00, "R11 ch7 end with chan=0");
    beat(1,1,1, 7,1,4'b1000, 8'h00, "R11 ch7 reopen after end");
    beat(0,1,1, 0,1,4'b0000, 8'h08, "R6 ch0 never opened");
    beat(0,1,1, 2,1,4'b1001, 8'h00, "R12 ch2 final burst");
    beat(0,1,1, 2,8,4'b0000, 8'h08, "R6 ch2 after close");
    beat(1,1,1, 4,8,4'b0000, 8'h00, "R13 ch4 reopen");
    quiet();

    do_reset();
    beat(1,1,0, 1,8,4'b0000, 8'h00, "R3 open burst");
    beat(0,1,1, 1,8,4'b0000, 8'h01, "R3 sob while open");
    quiet();

    do_reset();
    beat(0,0,0, 0,8,4'b0000, 8'h02, "R4 beat without burst");
    quiet();

    do_reset();
    beat(1,1,1, 5,8,4'b0000, 8'h00, "R5 ch5 open");
    beat(1,1,1, 5,8,4'b0000, 8'h04, "R5 sop on open ch5");
    beat(0,0,0, 5,0,4'b0000, 8'h00, "R14 pulse drops, flag held");
    beat(0,1,1, 5,8,4'b1000, 8'h00, "R14 clean beat keeps flag");
    quiet();

    do_reset();
    beat(0,1,1, 6,8,4'b0000, 8'h08, "R6 sob without sop");
    quiet();

    do_reset();
    beat(1,1,0, 1,8,4'b0000, 8'h00, "R7 open ch1");
    beat(1,0,1, 1,8,4'b0000, 8'h14, "R7 sop without sob");
    quiet();

    do_reset();
    beat(1,1,0, 2,8,4'b1010, 8'h20, "R8 eop flag without eob");
    beat(0,0,1, 2,8,4'b0000, 8'h00, "R8 burst end after");
    beat(1,1,1, 2,8,4'b1000, 8'h00, "R12 ch2 closed by flag");
    quiet();

    do_reset();
    beat(1,1,1, 0,9,4'b1000, 8'h40, "R9 count 9");
    beat(1,1,1, 1,15,4'b1000, 8'h40, "R9 count 15");
    beat(1,1,1, 2,8,4'b1000, 8'h00, "R9 count 8 legal");
    quiet();

    do_reset();
    beat(1,1,1, 3,8,4'b0011, 8'h80, "R10 byte count without flag");
    beat(1,1,1, 3,8,4'b0000, 8'h04, "R10 ch3 still open");
    quiet();

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule